// File: doc/BRIEF.md
# Configuration Startup Mode Sequencer

This block steps a programmable device from power-up to the end of its configuration phase. Right after reset it pulls a shared, active-low, open-drain initialisation line low while the internal configuration memory is being cleared. Once the clearing logic reports completion, it releases the line. It then waits for as long as any external agent keeps the line low. The first low-to-high transition seen on the line, after synchronisation, ends the wait. At that transition the block captures a three-bit configuration mode and a one-bit oscillator-speed select.

While configuration runs, the block produces a single-cycle configuration-clock enable from the system clock. The enable runs at one of two rates. The slow rate has a period exactly eight times the fast one, mirroring the choice between a 10 MHz and a 1.25 MHz internal oscillator. A pair of complementary busy indicators and an output-enable flag for those indicators show that configuration is not yet complete. When a done input arrives, the indicators change level and the output enable drops, which hands the pins over to user logic. The captured mode and speed then stay fixed until the next reset.

Top module: `cfg_seq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters the clearing state: `init_pull_low_o`=1, `busy_high_o`=1, `busy_low_o`=0, `status_oe_o`=1, `cclk_en_o`=0, `mode_o`=0 and `osc_slow_o`=0 after that edge.
- R2: `init_pull_low_o` stays 1 until `clear_done_i` is sampled high. It is 0 from the following clock edge on.
- R3: After the clearing state, the first rising edge of `init_sense_i` passes through a two-flop synchronizer. `mode_o` and `osc_slow_o` then take the values of `mode_sel_i` and `osc_slow_i` in the third clock edge after the line goes high, and configuration starts in that same cycle. Before that edge they still show their reset values.
- R4: While the sensed line stays low after clearing, no configuration starts: `cclk_en_o` stays 0, `mode_o` does not change and `cfg_done_i` is ignored.
- R5: `mode_o` and `osc_slow_o` do not change between the capture edge and the next reset, whatever `mode_sel_i`, `osc_slow_i` or the line do.
- R6: During configuration, `cclk_en_o` is a one-cycle pulse. Its period is `FAST_DIV` cycles when `osc_slow_o`=0 and 8×`FAST_DIV` cycles when `osc_slow_o`=1. The first pulse comes period−1 cycles after the cycle in which configuration starts.
- R7: `busy_high_o` stays 1 and `busy_low_o` stays 0 until `cfg_done_i` is sampled high during configuration. From the next edge on, `busy_high_o`=0, `busy_low_o`=1 and `status_oe_o`=0.
- R8: Once configuration is done, the block stays there until reset, with `cclk_en_o`=0, whatever the other inputs do.
- R9: `init_pull_low_o` is never asserted again after it has been released, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel_i | input | MODE_W | Configuration mode select, captured at the line's rising edge |
| osc_slow_i | input | 1 | Oscillator speed select (1 = slow), captured with the mode |
| init_sense_i | input | 1 | Sensed level of the shared initialisation line |
| clear_done_i | input | 1 | Memory clearing has finished |
| cfg_done_i | input | 1 | Configuration has completed |
| init_pull_low_o | output | 1 | Open-drain pull-down enable for the initialisation line |
| busy_high_o | output | 1 | High while configuration is incomplete |
| busy_low_o | output | 1 | Low while configuration is incomplete |
| status_oe_o | output | 1 | Output enable of the busy indicators; drops when done |
| mode_o | output | MODE_W | Captured configuration mode |
| osc_slow_o | output | 1 | Captured oscillator speed select |
| cclk_en_o | output | 1 | Configuration clock enable pulse |

## Verification
A wrong state shows up within one clock at the busy indicators or the pull-down enable. The only exception is the wait state versus the configure state. That difference is visible only through `cclk_en_o`, so it can take up to one slow period (8×`FAST_DIV` cycles) to appear. A capture made at the wrong time shows up as a wrong `mode_o` on the exact third edge after the line rises. Mode inputs that keep changing during the wait, and again after capture, expose any early or repeated capture. A divider that wraps at the wrong count shows up in the cycle of the first pulse, period−1 cycles into configuration.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the configuration startup sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_seq_pkg;

    // Phases of the startup sequence, in the order they are visited.
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_CONFIG = 2'd2,
        ST_DONE   = 2'd3
    } cfg_state_e;

    // Ratio between the slow and fast configuration clock periods.
    localparam int SLOW_FACTOR = 8;

endpackage

// File: rtl/cfg_init_edge.sv
`timescale 1ns/1ps
// Synchronises the sensed initialisation line and flags its rising edge.
// Assumes: the pad level is asynchronous to clk; SYNC_STAGES >= 2.
module cfg_init_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] chain_q;

    // Shift the pad level through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pad_i};
        end
    end

    // Rising edge on the synchronised level.
    always_comb begin
        rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end
endmodule

// File: rtl/cfg_cclk_gen.sv
`timescale 1ns/1ps
// Produces a one-cycle configuration clock enable at a fast or slow rate.
// Assumes: slow_i is stable while run_i is high; FAST_DIV >= 2.
module cfg_cclk_gen
    import cfg_seq_pkg::*;
#(
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int SLOW_DIV = FAST_DIV * SLOW_FACTOR;
    localparam int CNT_W    = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    // Select the terminal count for the chosen rate.
    always_comb begin
        limit = slow_i ? SLOW_LIM : FAST_LIM;
        wrap  = (cnt_q == limit);
    end

    // Count while running; restart from zero when idle or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pulse on the terminal count.
    always_comb begin
        tick_o = run_i & wrap;
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
`timescale 1ns/1ps
// Startup state machine: clear, wait for the line, configure, done.
// Captures mode and speed once, on the line's synchronised rising edge.
// Assumes: mode and speed inputs are stable around that edge.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_done_i,
    input  logic              init_rise_i,
    input  logic              cfg_done_i,
    input  logic [MODE_W-1:0] mode_sel_i,
    input  logic              osc_slow_i,
    output cfg_state_e        state_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              slow_o
);
    cfg_state_e        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              slow_q;
    logic              capture;

    // Next-state selection for the startup sequence.
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_CLEAR:  if (clear_done_i) state_d = ST_WAIT;
            ST_WAIT: begin
                if (init_rise_i) begin
                    state_d = ST_CONFIG;
                    capture = 1'b1;
                end
            end
            ST_CONFIG: if (cfg_done_i) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_CLEAR;
        endcase
    end

    // State register with synchronous reset to the clearing phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode and speed capture, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            slow_q <= 1'b0;
        end else if (capture) begin
            mode_q <= mode_sel_i;
            slow_q <= osc_slow_i;
        end
    end

    always_comb begin
        state_o = state_q;
        mode_o  = mode_q;
        slow_o  = slow_q;
    end
endmodule

// File: rtl/cfg_seq_top.sv
`timescale 1ns/1ps
// Configuration startup sequencer top: ties the line synchronizer, the
// state machine and the configuration clock enable generator together
// and decodes the pad-facing status outputs.
// Assumes: init_sense_i is the wired level of an open-drain line that this
// block pulls low through init_pull_low_o.
module cfg_seq_top
    import cfg_seq_pkg::*;
#(
    parameter int MODE_W      = 3,
    parameter int FAST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel_i,
    input  logic              osc_slow_i,
    input  logic              init_sense_i,
    input  logic              clear_done_i,
    input  logic              cfg_done_i,
    output logic              init_pull_low_o,
    output logic              busy_high_o,
    output logic              busy_low_o,
    output logic              status_oe_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              osc_slow_o,
    output logic              cclk_en_o
);
    cfg_state_e state;
    logic       init_rise;

    cfg_init_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (init_sense_i),
        .rise_o (init_rise)
    );

    cfg_seq_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_done_i (clear_done_i),
        .init_rise_i  (init_rise),
        .cfg_done_i   (cfg_done_i),
        .mode_sel_i   (mode_sel_i),
        .osc_slow_i   (osc_slow_i),
        .state_o      (state),
        .mode_o       (mode_o),
        .slow_o       (osc_slow_o)
    );

    cfg_cclk_gen #(.FAST_DIV(FAST_DIV)) u_cclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_CONFIG),
        .slow_i (osc_slow_o),
        .tick_o (cclk_en_o)
    );

    // Pad-facing status decode from the current phase.
    always_comb begin
        init_pull_low_o = (state == ST_CLEAR);
        busy_high_o     = (state != ST_DONE);
        busy_low_o      = (state == ST_DONE);
        status_oe_o     = (state != ST_DONE);
    end
endmodule

// File: rtl/cfg_seq_checker.sv
`timescale 1ns/1ps
// Port-level property checker for cfg_seq_top, attached by bind.
// Assumes: FAST_DIV >= 2 so enable pulses never touch.
module cfg_seq_checker #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_done_i,
    input logic              cfg_done_i,
    input logic              init_pull_low_o,
    input logic              busy_high_o,
    input logic              status_oe_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              osc_slow_o,
    input logic              cclk_en_o
);
    AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        init_pull_low_o && !clear_done_i |=> init_pull_low_o); // R2
    AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !init_pull_low_o |=> !init_pull_low_o); // R9
    AST_NO_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        init_pull_low_o |-> !cclk_en_o); // R4
    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en_o |=> !cclk_en_o); // R6
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        status_oe_o && !cfg_done_i |=> status_oe_o && busy_high_o); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_oe_o |=> !status_oe_o && !busy_high_o); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !status_oe_o |-> !cclk_en_o); // R8
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !status_oe_o |=> $stable(mode_o) && $stable(osc_slow_o)); // R5
    AST_MODE_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en_o |=> $stable(mode_o) && $stable(osc_slow_o)); // R5
endmodule

bind cfg_seq_top cfg_seq_checker #(.MODE_W(MODE_W)) u_chk (.*);

// File: tb/cfg_seq_top_tb_top.sv
`timescale 1ns/1ps
// Sweeps every mode and speed combination through a full startup sequence.
module cfg_seq_top_tb_top;
    localparam int MODE_W   = 3;
    localparam int FAST_DIV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MODE_W-1:0] mode_sel_i = '0;
    logic              osc_slow_i = 1'b0;
    logic              init_sense_i;
    logic              clear_done_i = 1'b0;
    logic              cfg_done_i = 1'b0;
    logic              init_pull_low_o, busy_high_o, busy_low_o, status_oe_o;
    logic [MODE_W-1:0] mode_o;
    logic              osc_slow_o, cclk_en_o;
    logic              ext_hold = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Wired open-drain line with a pull-up.
    assign init_sense_i = ~(init_pull_low_o | ext_hold);

    cfg_seq_top #(.MODE_W(MODE_W), .FAST_DIV(FAST_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i),
        .osc_slow_i(osc_slow_i), .init_sense_i(init_sense_i),
        .clear_done_i(clear_done_i), .cfg_done_i(cfg_done_i),
        .init_pull_low_o(init_pull_low_o), .busy_high_o(busy_high_o),
        .busy_low_o(busy_low_o), .status_oe_o(status_oe_o),
        .mode_o(mode_o), .osc_slow_o(osc_slow_o), .cclk_en_o(cclk_en_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            logic [MODE_W-1:0] m;
            logic s;
            int per;
            m = MODE_W'(i);
            s = (i >= 8);
            per = s ? FAST_DIV * 8 : FAST_DIV;

            // R1: reset, with inputs set to the opposite of the later capture
            rst_n = 1'b0; ext_hold = 1'b1; clear_done_i = 1'b0; cfg_done_i = 1'b0;
            mode_sel_i = ~m; osc_slow_i = ~s;
            tick(); tick();
            rst_n = 1'b1;
            check("R1 pull", int'(init_pull_low_o), 1);
            check("R1 busy_high", int'(busy_high_o), 1);
            check("R1 busy_low", int'(busy_low_o), 0);
            check("R1 oe", int'(status_oe_o), 1);
            check("R1 cclk", int'(cclk_en_o), 0);
            check("R1 mode", int'(mode_o), 0);
            check("R1 slow", int'(osc_slow_o), 0);

            // R2: held while clearing, released one edge after clear_done
            for (int k = 0; k < 3; k++) begin
                tick();
                check("R2 hold", int'(init_pull_low_o), 1);
            end
            clear_done_i = 1'b1;
            tick();
            clear_done_i = 1'b0;
            check("R2 release", int'(init_pull_low_o), 0);

            // R4: external hold keeps the block waiting; done ignored
            for (int k = 0; k < 6; k++) begin
                mode_sel_i = MODE_W'(k);
                osc_slow_i = k[0];
                cfg_done_i = k[0];
                tick();
                check("R4 cclk", int'(cclk_en_o), 0);
                check("R4 mode", int'(mode_o), 0);
                check("R4 busy", int'(busy_high_o), 1);
            end
            cfg_done_i = 1'b0;

            // R3: capture three edges after release
            mode_sel_i = m; osc_slow_i = s;
            ext_hold = 1'b0;
            tick(); tick();
            check("R3 early mode", int'(mode_o), 0);
            check("R3 early slow", int'(osc_slow_o), 0);
            tick();
            check("R3 mode", int'(mode_o), int'(m));
            check("R3 slow", int'(osc_slow_o), int'(s));
            mode_sel_i = ~m; osc_slow_i = ~s;

            // R6: pulse pattern; R5: latched values held
            for (int n = 0; n < 3 * per; n++) begin
                check("R6 cclk", int'(cclk_en_o), ((n % per) == per - 1) ? 1 : 0);
                check("R5 mode", int'(mode_o), int'(m));
                check("R7 busy", int'(busy_high_o), 1);
                ext_hold = n[1];
                tick();
            end
            ext_hold = 1'b0;

            // R7: done
            cfg_done_i = 1'b1;
            tick();
            cfg_done_i = 1'b0;
            check("R7 busy_high", int'(busy_high_o), 0);
            check("R7 busy_low", int'(busy_low_o), 1);
            check("R7 oe", int'(status_oe_o), 0);

            // R8, R9, R5: stays done under arbitrary inputs
            for (int k = 0; k < 8; k++) begin
                clear_done_i = k[0]; ext_hold = k[1]; cfg_done_i = k[2];
                mode_sel_i = MODE_W'(k);
                tick();
                check("R8 oe", int'(status_oe_o), 0);
                check("R8 cclk", int'(cclk_en_o), 0);
                check("R9 pull", int'(init_pull_low_o), 0);
                check("R5 mode", int'(mode_o), int'(m));
                check("R5 slow", int'(osc_slow_o), int'(s));
            end
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule